// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block decides when a processor core may stop its system clock for a low-power halt, and how the core comes back. A halt command from the core turns the system clock off and records that a power-down took place. While halted, the controller watches four wake sources: an external reset, a watchdog time-out, newly raised interrupt requests, and falling edges on port pins whose wake bit is set. The first wake source seen turns the system clock back on. The controller then counts a fixed settling window of system-clock cycles before it lets the core continue.

When the settling window closes, the controller issues exactly one action pulse:
- A full reset after an external reset.
- A warm reset of only the program counter and stack pointer after a watchdog time-out.
- A take-interrupt pulse when the waking interrupt is enabled and the stack has room.
- Otherwise, a resume-at-next-instruction pulse.

Two sticky flags, a power-down flag and a time-out flag, let software work out why the core restarted. Outside the halt state, a watchdog time-out or an external reset requests a full reset at once.

Top module: `hwk_ctrl`

## Requirements
- R1: After power-up reset the system clock is enabled, the halted status is low, all four action pulses are low, and both the time-out flag and the power-down flag are 0.
- R2: A halt command in the running state causes the following, one cycle later: halted high, system clock enable low, power-down flag 1 and time-out flag 0.
- R3: A clear-watchdog command in the running state (with no reset, time-out or halt command in the same cycle) clears the power-down flag one cycle later and leaves the time-out flag unchanged.
- R4: Outside the halt state an external reset produces a one-cycle full-reset pulse in the next cycle and leaves both flags unchanged. If the controller is settling, it returns to running and gives no later action pulse. A watchdog time-out in the running state without external reset produces the same pulse and sets the time-out flag.
- R5: While halted, the wake sources have this priority: external reset, then watchdog time-out, then interrupt, then port pin. With no wake source the controller stays halted with the system clock off.
- R6: The system clock enable rises on the clock edge that samples the wake source. The action pulse appears exactly SETTLE_CYCLES cycles after that edge. Before then no action pulse occurs.
- R7: The action pulse depends on the winning wake source: external reset gives full reset; watchdog time-out gives warm reset and sets the time-out flag at wake; port-pin wake gives resume-next-instruction.
- R8: An interrupt wake gives take-interrupt when the waking request's enable bit is 1 and the stack-full input is 0 at the wake edge. Otherwise it gives resume-next-instruction.
- R9: The following do not wake the controller: an interrupt request already high at the halt command, until it has dropped and risen again; a pin already low at halt entry; a falling pin whose wake bit is 0.
- R10: At most one action pulse is high in any cycle, and each lasts one cycle.
- R11: During settling, halt commands, clear-watchdog commands and watchdog time-outs have no effect on state, flags or pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| halt_cmd_i | input | 1 | Halt command from the core |
| clrwdt_i | input | 1 | Clear-watchdog command from the core |
| ext_rst_i | input | 1 | Synchronised external reset request |
| wdt_tmo_i | input | 1 | Watchdog time-out pulse |
| irq_req_i | input | NIRQ | Interrupt request flags |
| irq_en_i | input | NIRQ | Interrupt enable bits |
| stack_full_i | input | 1 | Return stack has no free entry |
| pin_i | input | NPIN | Port pin levels |
| pin_wake_en_i | input | NPIN | Per-pin wake enable |
| sysclk_en_o | output | 1 | System clock enable for the core |
| halted_o | output | 1 | Controller is in the halt state |
| warm_rst_o | output | 1 | Reset program counter and stack pointer only |
| full_rst_o | output | 1 | Full device reset request |
| resume_next_o | output | 1 | Continue at the next instruction |
| take_irq_o | output | 1 | Take the normal interrupt response |
| to_flag_o | output | 1 | Sticky watchdog time-out flag |
| pdf_flag_o | output | 1 | Sticky power-down flag |

## Verification
The assertions assume that every input is synchronous to `clk` and that no halt command arrives while the controller is settling, other than the ones the requirements say are ignored. They also assume that the stack-full level is the one that holds at the wake edge. The stimulus changes inputs only on falling clock edges, holds each wake source for a single cycle, and returns the pins high once the controller is running again. Simultaneous wake sources are applied in the same cycle, on purpose, to exercise the priority order. Halt commands, clear-watchdog commands and watchdog pulses are sent during settling only in the one test that expects them to be ignored.

// File: rtl/hwk_pkg.sv
package hwk_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_HALT   = 2'd1,
      ST_SETTLE = 2'd2
   } hwk_state_e;

   // ordered by wake priority, lowest first
   typedef enum logic [1:0] {
      ACT_RESUME = 2'd0,
      ACT_TAKE   = 2'd1,
      ACT_WARM   = 2'd2,
      ACT_FULL   = 2'd3
   } hwk_act_e;

endpackage

// File: rtl/hwk_wake_src.sv
module hwk_wake_src #(
   parameter int NPIN = 8,
   parameter int NIRQ = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halted_i,
   input  logic            enter_i,
   input  logic [NPIN-1:0] pin_i,
   input  logic [NPIN-1:0] pin_en_i,
   input  logic [NIRQ-1:0] irq_req_i,
   input  logic [NIRQ-1:0] irq_en_i,
   input  logic            stack_full_i,
   output logic            pin_wake_o,
   output logic            irq_wake_o,
   output logic            irq_take_o
);

   initial begin
      if (NPIN < 1 || NIRQ < 1) $fatal(1, "hwk_wake_src: NPIN and NIRQ must be at least 1");
   end

   logic [NPIN-1:0] pin_prev_q;
   logic [NPIN-1:0] pin_fall;
   logic [NIRQ-1:0] blk;
   logic [NIRQ-1:0] fresh;

   // previous pin sample, tracked every cycle so that only edges
   // between two samples taken at or after halt entry can wake
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev_q <= '1;
      else        pin_prev_q <= pin_i;
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign pin_fall[p] = pin_en_i[p] & pin_prev_q[p] & ~pin_i[p];
   end

   // per-request blocking: a request high at halt entry is masked
   // until it drops while halted
   for (genvar q = 0; q < NIRQ; q++) begin : g_irq
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        b_q <= 1'b0;
         else if (enter_i)  b_q <= irq_req_i[q];
         else if (halted_i) b_q <= b_q & irq_req_i[q];
         else               b_q <= 1'b0;
      end
      assign blk[q]   = b_q;
      assign fresh[q] = irq_req_i[q] & ~b_q;
   end

   assign pin_wake_o = halted_i & (|pin_fall);
   assign irq_wake_o = halted_i & (|fresh);
   assign irq_take_o = (|(fresh & irq_en_i)) & ~stack_full_i;

   AST_BLOCK_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_i && $past(halted_i)) |-> ((blk & ~$past(blk)) == '0)); // R9

endmodule

// File: rtl/hwk_settle.sv
module hwk_settle #(
   parameter int SETTLE_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic busy_o,
   output logic done_o
);

   localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

   initial begin
      if (SETTLE_CYCLES < 2) $fatal(1, "hwk_settle: SETTLE_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q & (cnt_q == LAST) & ~abort_i;

   AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (cnt_q == '0)); // R6
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R6

endmodule

// File: rtl/hwk_flags.sv
module hwk_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pdf_i,
   input  logic clr_pdf_i,
   input  logic set_to_i,
   input  logic clr_to_i,
   output logic pdf_o,
   output logic to_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdf_o <= 1'b0;
         to_o  <= 1'b0;
      end else begin
         if (set_pdf_i)      pdf_o <= 1'b1;
         else if (clr_pdf_i) pdf_o <= 1'b0;
         if (set_to_i)       to_o  <= 1'b1;
         else if (clr_to_i)  to_o  <= 1'b0;
      end
   end

   AST_PDF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pdf_i && !set_pdf_i) |=> !pdf_o); // R3
   AST_TO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_to_i && !clr_to_i) |=> (to_o == $past(to_o))); // R3

endmodule

// File: rtl/hwk_ctrl.sv
module hwk_ctrl
   import hwk_pkg::*;
#(
   parameter int NPIN          = 8,
   parameter int NIRQ          = 4,
   parameter int SETTLE_CYCLES = 1024
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt_cmd_i,
   input  logic            clrwdt_i,
   input  logic            ext_rst_i,
   input  logic            wdt_tmo_i,
   input  logic [NIRQ-1:0] irq_req_i,
   input  logic [NIRQ-1:0] irq_en_i,
   input  logic            stack_full_i,
   input  logic [NPIN-1:0] pin_i,
   input  logic [NPIN-1:0] pin_wake_en_i,
   output logic            sysclk_en_o,
   output logic            halted_o,
   output logic            warm_rst_o,
   output logic            full_rst_o,
   output logic            resume_next_o,
   output logic            take_irq_o,
   output logic            to_flag_o,
   output logic            pdf_flag_o
);

   hwk_state_e st_q;
   hwk_act_e   cause_q;
   hwk_act_e   wake_cause;

   logic in_run, in_halt, in_settle;
   logic ext_now, run_wdt, halt_wdt, enter, clr_pdf;
   logic pin_wake, irq_wake, irq_take, wake_any;
   logic settle_busy, settle_done;
   logic full_q, warm_q, take_q, resume_q;

   assign in_run    = (st_q == ST_RUN);
   assign in_halt   = (st_q == ST_HALT);
   assign in_settle = (st_q == ST_SETTLE);

   hwk_wake_src #(.NPIN(NPIN), .NIRQ(NIRQ)) u_wake (
      .clk          (clk),
      .rst_n        (rst_n),
      .halted_i     (in_halt),
      .enter_i      (enter),
      .pin_i        (pin_i),
      .pin_en_i     (pin_wake_en_i),
      .irq_req_i    (irq_req_i),
      .irq_en_i     (irq_en_i),
      .stack_full_i (stack_full_i),
      .pin_wake_o   (pin_wake),
      .irq_wake_o   (irq_wake),
      .irq_take_o   (irq_take)
   );

   // command decode, priority: external reset, time-out, halt, clear
   assign ext_now  = ext_rst_i & ~in_halt;
   assign run_wdt  = in_run & ~ext_rst_i & wdt_tmo_i;
   assign halt_wdt = in_halt & ~ext_rst_i & wdt_tmo_i;
   assign enter    = in_run & ~ext_rst_i & ~wdt_tmo_i & halt_cmd_i;
   assign clr_pdf  = in_run & ~ext_rst_i & ~wdt_tmo_i & ~halt_cmd_i & clrwdt_i;
   assign wake_any = in_halt & (ext_rst_i | wdt_tmo_i | irq_wake | pin_wake);

   always_comb begin
      if (ext_rst_i)                 wake_cause = ACT_FULL;
      else if (wdt_tmo_i)            wake_cause = ACT_WARM;
      else if (irq_wake && irq_take) wake_cause = ACT_TAKE;
      else                           wake_cause = ACT_RESUME;
   end

   hwk_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (wake_any),
      .abort_i (ext_now),
      .busy_o  (settle_busy),
      .done_o  (settle_done)
   );

   hwk_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pdf_i (enter),
      .clr_pdf_i (clr_pdf),
      .set_to_i  (run_wdt | halt_wdt),
      .clr_to_i  (enter),
      .pdf_o     (pdf_flag_o),
      .to_o      (to_flag_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         cause_q <= ACT_RESUME;
      end else if (ext_now) begin
         st_q <= ST_RUN;
      end else begin
         unique case (st_q)
            ST_RUN:    if (enter) st_q <= ST_HALT;
            ST_HALT:   if (wake_any) begin
                          st_q    <= ST_SETTLE;
                          cause_q <= wake_cause;
                       end
            ST_SETTLE: if (settle_done) st_q <= ST_RUN;
            default:   st_q <= ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q   <= 1'b0;
         warm_q   <= 1'b0;
         take_q   <= 1'b0;
         resume_q <= 1'b0;
      end else begin
         full_q   <= ext_now | run_wdt | (settle_done && cause_q == ACT_FULL);
         warm_q   <= settle_done && cause_q == ACT_WARM;
         take_q   <= settle_done && cause_q == ACT_TAKE;
         resume_q <= settle_done && cause_q == ACT_RESUME;
      end
   end

   assign sysclk_en_o   = ~in_halt;
   assign halted_o      = in_halt;
   assign full_rst_o    = full_q;
   assign warm_rst_o    = warm_q;
   assign take_irq_o    = take_q;
   assign resume_next_o = resume_q;

   AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (halted_o && pdf_flag_o && !to_flag_o)); // R2
   AST_RUN_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      run_wdt |=> (full_rst_o && to_flag_o)); // R4
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_halt && !ext_rst_i && !wdt_tmo_i && !irq_wake && !pin_wake) |=> halted_o); // R5
   AST_SETTLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      in_settle |-> settle_busy); // R6
   AST_WARM_HAS_TO: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_o |-> to_flag_o); // R7
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({full_rst_o, warm_rst_o, take_irq_o, resume_next_o})); // R10
   AST_SETTLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_settle && !ext_rst_i) |=> ($stable(pdf_flag_o) && $stable(to_flag_o) && !halted_o)); // R11

endmodule

// File: tb/hwk_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwk_ctrl_tb_top;

   localparam int NP  = 8;
   localparam int NI  = 4;
   localparam int DLY = 1024;
   localparam int NV  = 10;

   // fields: [28:21] falling pins, [20:13] pin wake enables, [12:9] irq,
   // [8:5] irq enables, [4] stack full, [3] time-out, [2] ext reset,
   // [1:0] action code 0 resume, 1 take, 2 warm, 3 full
   localparam logic [28:0] VEC [NV] = '{
      {8'h01, 8'h01, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0},
      {8'h80, 8'hFF, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0},
      {8'h00, 8'h00, 4'h2, 4'h2, 1'b0, 1'b0, 1'b0, 2'd1},
      {8'h00, 8'h00, 4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0},
      {8'h00, 8'h00, 4'h4, 4'h4, 1'b1, 1'b0, 1'b0, 2'd0},
      {8'h00, 8'h00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 2'd2},
      {8'h00, 8'h00, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 2'd3},
      {8'h00, 8'h00, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 2'd3},
      {8'h01, 8'h01, 4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 2'd1},
      {8'h00, 8'h00, 4'h8, 4'h8, 1'b0, 1'b1, 1'b0, 2'd2}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic halt_cmd, clrwdt, ext_rst, wdt_tmo, stack_full;
   logic [NI-1:0] irq_req, irq_en;
   logic [NP-1:0] pin, pin_en;
   logic sysclk_en, halted, warm_rst, full_rst, resume_next, take_irq, to_flag, pdf_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   hwk_ctrl #(.NPIN(NP), .NIRQ(NI), .SETTLE_CYCLES(DLY)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .halt_cmd_i    (halt_cmd),
      .clrwdt_i      (clrwdt),
      .ext_rst_i     (ext_rst),
      .wdt_tmo_i     (wdt_tmo),
      .irq_req_i     (irq_req),
      .irq_en_i      (irq_en),
      .stack_full_i  (stack_full),
      .pin_i         (pin),
      .pin_wake_en_i (pin_en),
      .sysclk_en_o   (sysclk_en),
      .halted_o      (halted),
      .warm_rst_o    (warm_rst),
      .full_rst_o    (full_rst),
      .resume_next_o (resume_next),
      .take_irq_o    (take_irq),
      .to_flag_o     (to_flag),
      .pdf_flag_o    (pdf_flag)
   );

   function automatic logic [3:0] acts();
      return {full_rst, warm_rst, take_irq, resume_next};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_halt();
      @(negedge clk) halt_cmd = 1'b1;
      @(negedge clk) halt_cmd = 1'b0;
      chk("R2", {28'd0, halted, sysclk_en, pdf_flag, to_flag}, 32'b1010);
   endtask

   // called at the falling edge where the wake inputs were just applied
   task automatic wake_expect(input logic [1:0] code, input string req, input bit inject);
      @(posedge clk);
      @(negedge clk);
      wdt_tmo = 1'b0; ext_rst = 1'b0; irq_req = '0; pin = '1;
      chk("R6", {30'd0, halted, sysclk_en}, 32'b01);
      if (inject) begin
         @(negedge clk) begin halt_cmd = 1'b1; wdt_tmo = 1'b1; clrwdt = 1'b1; end
         @(negedge clk) begin halt_cmd = 1'b0; wdt_tmo = 1'b0; clrwdt = 1'b0; end
         chk("R11", {26'd0, halted, sysclk_en, acts(), pdf_flag}, {26'd0, 1'b0, 1'b1, 4'b0000, 1'b1});
         repeat (DLY - 3) @(negedge clk);
      end else begin
         repeat (DLY - 1) @(negedge clk);
      end
      chk("R6", {28'd0, acts()}, 32'd0);
      @(negedge clk);
      chk(req, {28'd0, acts()}, 32'd1 << code);
      chk("R6", {30'd0, halted, sysclk_en}, 32'b01);
      @(negedge clk);
      chk("R10", {28'd0, acts()}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; halt_cmd = 1'b0; clrwdt = 1'b0; ext_rst = 1'b0; wdt_tmo = 1'b0;
      stack_full = 1'b0; irq_req = '0; irq_en = '0; pin = '1; pin_en = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {24'd0, sysclk_en, halted, acts(), to_flag, pdf_flag}, {24'd0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0});

      // R4 time-out while running
      @(negedge clk) wdt_tmo = 1'b1;
      @(negedge clk) wdt_tmo = 1'b0;
      chk("R4", {27'd0, acts(), to_flag}, {27'd0, 4'b1000, 1'b1});
      @(negedge clk);
      chk("R10", {28'd0, acts()}, 32'd0);

      // R4 external reset while running keeps the flags
      @(negedge clk) ext_rst = 1'b1;
      @(negedge clk) ext_rst = 1'b0;
      chk("R4", {26'd0, acts(), to_flag, pdf_flag}, {26'd0, 4'b1000, 1'b1, 1'b0});

      // table of wake scenarios
      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         int nsrc;
         string req;
         v = VEC[i];
         do_halt();
         pin = ~v[28:21]; pin_en = v[20:13]; irq_req = v[12:9]; irq_en = v[8:5];
         stack_full = v[4]; wdt_tmo = v[3]; ext_rst = v[2];
         nsrc = int'(v[28:21] != 0) + int'(v[12:9] != 0) + int'(v[3]) + int'(v[2]);
         req = (nsrc > 1) ? "R5" : ((v[12:9] != 0) ? "R8" : "R7");
         wake_expect(v[1:0], req, 1'b0);
         chk("R7", {31'd0, to_flag}, {31'd0, v[1:0] == 2'd2});
         stack_full = 1'b0; pin_en = '0; irq_en = '0;
      end

      // R3 clear-watchdog clears only the power-down flag
      begin
         logic to_before;
         to_before = to_flag;
         @(negedge clk) clrwdt = 1'b1;
         @(negedge clk) clrwdt = 1'b0;
         chk("R3", {30'd0, pdf_flag, to_flag}, {30'd0, 1'b0, to_before});
      end

      // R9 pin low at entry and a disabled falling pin do not wake
      pin = 8'hFB; pin_en = 8'h04;
      do_halt();
      pin = 8'hF9;
      repeat (8) @(negedge clk);
      chk("R9", {30'd0, halted, sysclk_en}, 32'b10);
      wdt_tmo = 1'b1;
      wake_expect(2'd2, "R5", 1'b0);
      pin_en = '0;

      // R9 request pending at halt is blocked until it drops
      irq_req = 4'b0001; irq_en = 4'b0001;
      do_halt();
      repeat (6) @(negedge clk);
      chk("R9", {31'd0, halted}, 32'd1);
      irq_req = '0;
      @(negedge clk) irq_req = 4'b0001;
      wake_expect(2'd1, "R9", 1'b0);
      irq_en = '0;

      // R11 commands during settling are ignored
      pin_en = 8'h01;
      do_halt();
      pin = 8'hFE;
      wake_expect(2'd0, "R11", 1'b1);

      // R4 external reset during settling
      do_halt();
      pin = 8'hFE;
      @(posedge clk);
      @(negedge clk) pin = '1;
      repeat (2) @(negedge clk);
      ext_rst = 1'b1;
      @(negedge clk) ext_rst = 1'b0;
      chk("R4", {26'd0, acts(), halted, sysclk_en}, {26'd0, 4'b1000, 1'b0, 1'b1});
      begin
         int extra;
         extra = 0;
         @(negedge clk);
         for (int k = 0; k < DLY + 4; k++) begin
            @(negedge clk);
            if (acts() != 4'b0000) extra++;
         end
         chk("R4", extra, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule